// File: doc/BRIEF.md
# Bus Stall Watchdog Timer

This block watches a serial-bus transfer for stalls, such as a clock line held low by a slow or stuck device. A 15-bit up-counter advances on ticks from a power-of-two prescaler. It advances only while the timer is enabled and a transfer is in progress. When the count reaches the programmed limit, the block raises a sticky timeout flag. The flag stays set until software clears it.

Software programs the block through a small write port with three targets. The control word carries the limit and an enable bit. A second register holds a 4-bit exponent that sets the tick period to 2^E core clocks. A status target clears the flag by writing a one. The bit engine that owns the transfer drives three signals. A busy level gates counting. A start pulse and a bus-activity pulse each restart the count, so that only a silent bus runs the timer out.

A 25 ms budget at a given core frequency is reached by choosing the smallest exponent that brings the scaled cycle count under 2^15, and then saturating the limit at 0x7FFF.

Top module: `bus_stall_watchdog`

## Requirements
- R1: After reset, ctrl_word, div_exp, timeout_flag and stat_word are all zero.
- R2: A write with wr_sel=0 loads ctrl_word. Bits 14:0 are the limit and bit 15 is the enable. ctrl_word reads back the value written, including when bit 15 is clear.
- R3: A write with wr_sel=1 loads div_exp from wr_data[3:0]. A write with wr_sel=3 changes neither ctrl_word nor div_exp.
- R4: From a restart with enable set, timeout_flag rises after exactly max(limit,1)·2^E clock edges on which xfer_busy was high. E is div_exp, for every E from 0 to 15.
- R5: The counter and prescaler hold their values while xfer_busy is low. While the enable bit is clear, timeout_flag never rises.
- R6: A pulse on xfer_start or bus_kick clears the counter and the prescaler. That edge does not count, so the full max(limit,1)·2^E busy edges are needed again.
- R7: A control write that sets the enable bit while it was clear restarts the count. A control write with the enable bit already set keeps the count in progress.
- R8: timeout_flag is sticky. A write with wr_sel=2 and wr_data[7]=1 clears it. The same write with wr_data[7]=0 leaves it set.
- R9: stat_word carries timeout_flag in bit 7, and all its other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 exponent, 2 status clear, 3 none |
| wr_data | input | 16 | Write data |
| xfer_busy | input | 1 | Transfer in progress; counting allowed |
| xfer_start | input | 1 | Start pulse; restarts the count |
| bus_kick | input | 1 | Bus activity pulse; restarts the count |
| ctrl_word | output | 16 | Control word readback (enable, limit) |
| div_exp | output | 4 | Prescale exponent readback |
| timeout_flag | output | 1 | Sticky timeout flag |
| stat_word | output | 16 | Status word, timeout flag in bit 7 |

## Verification
On every cycle, the assertions check the following. The count and the prescaler hold while not running. A restart leaves both at zero on the next cycle. A tick only occurs while running. The flag only rises after a tick and stays set until the clear write. The exponent register moves only when it is written. Only the bench can show the exact cycle at which the flag rises for a given limit and exponent. This includes a random busy pattern, the limit-zero case and the widest exponent. The bench also covers restarts in the middle of a count, the difference between re-enabling and rewriting an enabled word, and the full W1C behaviour.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
   localparam int LIMIT_W = 15;
   localparam int EXP_W   = 4;
   localparam int WORD_W  = LIMIT_W + 1;
   localparam int FLAG_BIT = 7;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_DIV  = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } wr_sel_e;
endpackage

// File: rtl/bsw_cfg_regs.sv
module bsw_cfg_regs #(
   parameter int LIMIT_W = 15,
   parameter int EXP_W   = 4,
   parameter int FLAG_BIT = 7,
   localparam int WORD_W = LIMIT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] ctrl_q,
   output logic [EXP_W-1:0]  exp_q,
   output logic              reenable,
   output logic              flag_clr
);
   import bsw_pkg::*;

   logic wr_ctrl, wr_div;

   assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
   assign wr_div   = wr_en && (wr_sel == SEL_DIV);
   assign flag_clr = wr_en && (wr_sel == SEL_STAT) && wr_data[FLAG_BIT];
   assign reenable = wr_ctrl && wr_data[WORD_W-1] && !ctrl_q[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= wr_data;
      end
   end

   generate
      if (EXP_W > 0) begin : g_exp_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               exp_q <= '0;
            end else if (wr_div) begin
               exp_q <= wr_data[EXP_W-1:0];
            end
         end
      end else begin : g_no_exp
         assign exp_q = '0;
      end
   endgenerate

   AST_EXP_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_div |=> $stable(exp_q)); // R3
   AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable(ctrl_q)); // R2
endmodule

// File: rtl/bsw_prescaler.sv
module bsw_prescaler #(
   parameter int EXP_W = 4,
   localparam int PRE_W = (EXP_W > 0) ? ((1 << EXP_W) - 1) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [EXP_W-1:0] exp_q,
   output logic             tick
);
   generate
      if (EXP_W == 0) begin : g_direct
         assign tick = run && !clr;
      end else begin : g_divider
         logic [PRE_W-1:0] pre_q;
         logic [PRE_W:0]   span;
         logic [PRE_W-1:0] mask;
         logic             wrap;

         assign span = ({{PRE_W{1'b0}}, 1'b1} << exp_q) - 1'b1;
         assign mask = span[PRE_W-1:0];
         assign wrap = (pre_q == mask);
         assign tick = run && !clr && wrap;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (clr) begin
               pre_q <= '0;
            end else if (run) begin
               pre_q <= wrap ? '0 : pre_q + 1'b1;
            end
         end

         AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (pre_q == '0)); // R6
         AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !clr) |=> $stable(pre_q)); // R5
      end
   endgenerate

   AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> run); // R5
endmodule

// File: rtl/bsw_limit_counter.sv
module bsw_limit_counter #(
   parameter int LIMIT_W = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               clr,
   input  logic               tick,
   input  logic [LIMIT_W-1:0] limit,
   input  logic               flag_clr,
   output logic               flag_q
);
   logic [LIMIT_W-1:0] cnt_q;
   logic [LIMIT_W:0]   cnt_next;
   logic               at_limit;
   logic               hit;

   assign cnt_next = {1'b0, cnt_q} + 1'b1;
   assign at_limit = (cnt_q >= limit);
   assign hit      = tick && (cnt_next >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (tick && !at_limit) begin
         cnt_q <= cnt_next[LIMIT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (hit) begin
         flag_q <= 1'b1;
      end else if (flag_clr) begin
         flag_q <= 1'b0;
      end
   end

   AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0)); // R6
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(cnt_q)); // R5
   AST_FLAG_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(tick)); // R4
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr) |=> flag_q); // R8
endmodule

// File: rtl/bus_stall_watchdog.sv
module bus_stall_watchdog #(
   parameter int LIMIT_W  = bsw_pkg::LIMIT_W,
   parameter int EXP_W    = bsw_pkg::EXP_W,
   parameter int FLAG_BIT = bsw_pkg::FLAG_BIT,
   localparam int WORD_W  = LIMIT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              xfer_busy,
   input  logic              xfer_start,
   input  logic              bus_kick,
   output logic [WORD_W-1:0] ctrl_word,
   output logic [EXP_W-1:0]  div_exp,
   output logic              timeout_flag,
   output logic [WORD_W-1:0] stat_word
);
   generate
      if (LIMIT_W < 1 || LIMIT_W > 30) begin : g_bad_limit
         $error("LIMIT_W out of range");
      end
      if (EXP_W < 1 || EXP_W > 4) begin : g_bad_exp
         $error("EXP_W must be 1 to 4");
      end
      if (FLAG_BIT >= WORD_W) begin : g_bad_flag
         $error("FLAG_BIT outside status word");
      end
   endgenerate

   logic reenable, flag_clr, run, clr, tick;

   bsw_cfg_regs #(
      .LIMIT_W (LIMIT_W),
      .EXP_W   (EXP_W),
      .FLAG_BIT(FLAG_BIT)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .ctrl_q  (ctrl_word),
      .exp_q   (div_exp),
      .reenable(reenable),
      .flag_clr(flag_clr)
   );

   assign run = ctrl_word[WORD_W-1] && xfer_busy;
   assign clr = xfer_start || bus_kick || reenable;

   bsw_prescaler #(.EXP_W(EXP_W)) i_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .clr  (clr),
      .exp_q(div_exp),
      .tick (tick)
   );

   bsw_limit_counter #(.LIMIT_W(LIMIT_W)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .clr     (clr),
      .tick    (tick),
      .limit   (ctrl_word[LIMIT_W-1:0]),
      .flag_clr(flag_clr),
      .flag_q  (timeout_flag)
   );

   always_comb begin
      stat_word           = '0;
      stat_word[FLAG_BIT] = timeout_flag;
   end

   AST_NO_FLAG_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_word[WORD_W-1] |=> !$rose(timeout_flag)); // R5
   AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(stat_word) == 32'(timeout_flag)); // R9
endmodule

// File: tb/test_bus_stall_watchdog.sv
module test_bus_stall_watchdog;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd3;
   logic [15:0] wr_data = '0;
   logic        xfer_busy = 1'b0;
   logic        xfer_start = 1'b0;
   logic        bus_kick = 1'b0;
   logic [15:0] ctrl_word;
   logic [3:0]  div_exp;
   logic        timeout_flag;
   logic [15:0] stat_word;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bus_stall_watchdog i_bus_stall_watchdog (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .xfer_busy(xfer_busy), .xfer_start(xfer_start),
      .bus_kick(bus_kick), .ctrl_word(ctrl_word), .div_exp(div_exp),
      .timeout_flag(timeout_flag), .stat_word(stat_word)
   );

   function automatic int expect_edges(int lim, int e);
      return ((lim == 0) ? 1 : lim) << e;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
   endtask

   task automatic pulse(input bit kick);
      @(negedge clk);
      if (kick) bus_kick = 1'b1; else xfer_start = 1'b1;
      @(negedge clk);
      bus_kick = 1'b0; xfer_start = 1'b0;
   endtask

   // Drives busy edges (optionally random) and returns busy edges until the flag.
   task automatic run_edges(input int limit_n, input bit rnd, output int n);
      n = 0;
      while (!timeout_flag && n <= limit_n + 2) begin
         xfer_busy = rnd ? (($urandom % 4) != 0) : 1'b1;
         if (xfer_busy) n++;
         @(negedge clk);
      end
      xfer_busy = 1'b0;
   endtask

   // Drives a fixed number of busy edges.
   task automatic busy_for(input int k);
      for (int i = 0; i < k; i++) begin
         xfer_busy = 1'b1;
         @(negedge clk);
      end
      xfer_busy = 1'b0;
   endtask

   task automatic arm(input int lim, input int e);
      wr(2'd0, {1'b0, 15'(lim)});
      wr(2'd1, 16'(e));
      wr(2'd2, 16'h0080);
      wr(2'd0, {1'b1, 15'(lim)});
   endtask

   initial begin
      int n;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ctrl", int'(ctrl_word), 0);
      chk("R1 exp", int'(div_exp), 0);
      chk("R1 flag", int'(timeout_flag), 0);
      chk("R1 stat", int'(stat_word), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 register readback, wr_sel=3 ignored
      wr(2'd0, 16'h1234);
      chk("R2 ctrl readback", int'(ctrl_word), 16'h1234);
      wr(2'd1, 16'h00A7);
      chk("R3 exp readback", int'(div_exp), 7);
      wr(2'd3, 16'hFFFF);
      chk("R3 sel3 ctrl", int'(ctrl_word), 16'h1234);
      chk("R3 sel3 exp", int'(div_exp), 7);

      // R4 directed: limit 3, exp 0
      arm(3, 0);
      run_edges(3, 1'b0, n);
      chk("R4 L3 E0", n, expect_edges(3, 0));
      // R9 status word
      chk("R9 stat", int'(stat_word), 16'h0080);
      // R8 sticky, W1C with bit7 clear ignored, then cleared
      wr(2'd0, 16'h0003);
      repeat (5) @(negedge clk);
      chk("R8 sticky", int'(timeout_flag), 1);
      wr(2'd2, 16'hFF7F);
      chk("R8 w1c bit7 clear", int'(timeout_flag), 1);
      wr(2'd2, 16'h0080);
      chk("R8 w1c clears", int'(timeout_flag), 0);
      chk("R9 stat cleared", int'(stat_word), 0);

      // R4 limit zero behaves as one
      arm(0, 2);
      run_edges(4, 1'b0, n);
      chk("R4 L0 E2", n, expect_edges(0, 2));

      // R5 disabled: no timeout, limit kept
      arm(2, 0);
      wr(2'd0, 16'h0002);
      busy_for(200);
      chk("R5 disabled no flag", int'(timeout_flag), 0);
      chk("R2 limit kept with enable clear", int'(ctrl_word), 2);

      // R6 kick and start restart the count
      arm(5, 1);
      busy_for(6);
      pulse(1'b1);
      run_edges(10, 1'b0, n);
      chk("R6 bus_kick restart", n, expect_edges(5, 1));
      arm(5, 1);
      busy_for(7);
      pulse(1'b0);
      run_edges(10, 1'b0, n);
      chk("R6 xfer_start restart", n, expect_edges(5, 1));

      // R7 rewriting an enabled word keeps the count
      arm(6, 0);
      busy_for(3);
      wr(2'd0, 16'h8006);
      run_edges(6, 1'b0, n);
      chk("R7 rewrite keeps count", n, 3);
      // R7 re-enable restarts
      arm(6, 0);
      busy_for(3);
      wr(2'd0, 16'h0006);
      wr(2'd0, 16'h8006);
      run_edges(6, 1'b0, n);
      chk("R7 reenable restarts", n, 6);

      // R4 R5 random limits, exponents and busy gaps
      for (int k = 0; k < 10; k++) begin
         int lim = int'($urandom % 40);
         int e = int'($urandom % 5);
         arm(lim, e);
         run_edges(expect_edges(lim, e), 1'b1, n);
         chk("R4 R5 random", n, expect_edges(lim, e));
      end

      // R4 widest exponent
      arm(1, 15);
      run_edges(expect_edges(1, 15), 1'b0, n);
      chk("R4 E15", n, expect_edges(1, 15));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule